// File: doc/BRIEF.md
# Dead-Block Correlating Prefetcher

This block watches the load/store accesses that reach a small direct-mapped L1 data cache and keeps the cache's tag array. Each resident frame also stores a running signature of the instructions that have touched it. An access that makes a frame's signature match a trained, confident entry in a correlation table marks that frame as dead: the frame has had its final reference. The block then issues a prefetch at once, without waiting for a later miss. The address it prefetches is the block that followed the dead one the last time, and that block maps to the same frame.

The correlation store has two levels. The frame's signature, folded with the block address, selects and tags an entry in a table of predicted successors. The table learns on eviction. When a demand miss displaces a valid frame, the victim's address and final signature are linked to the address that missed. The prefetch leaves on a valid/ready request port. `pf_req_valid` stays high and `pf_req_addr` stays stable until the consumer raises `pf_req_ready`; the handshake completes on a cycle in which both are high. The consumer returns the data with a one-cycle `pf_fill` pulse, and the block installs the predicted block straight into its frame. No side buffer is involved. Only one prefetch may be in flight at a time.

Top module: `dbcp_prefetcher`

## Requirements
- R1: After reset every frame is empty, every correlation entry is invalid, no prefetch is pending, and `acc_hit`, `acc_miss` and `pf_req_valid` are 0.
- R2: An access with `acc_valid`=1 is answered one cycle later by exactly one of `acc_hit` or `acc_miss`. The frame index is `acc_addr[5:0]` (64 frames) and the remaining address bits are the tag. A miss fills the frame with the accessed block.
- R3: A miss sets the frame signature to the 16-bit PC. A hit sets it to the old signature plus the PC, modulo 2^16.
- R4: A miss that displaces a valid frame trains the table. The key is victim_addr XOR zero-extended victim signature; the entry index is key[5:0] and the entry tag is the full key. If the entry is valid with that tag and its next address equals the missing address, its 2-bit confidence goes up and saturates at 3. Otherwise, if the entry is invalid or its confidence is 0, it is replaced with the new tag, next = missing address and confidence 1. In all other cases the confidence goes down by 1.
- R5: Every access looks up the key formed from `acc_addr` and the frame's updated signature. A valid entry with a matching tag and confidence of at least 2 is a dead prediction. If no prefetch is pending, `pf_req_valid` rises one cycle later, with `pf_req_addr` equal to the entry's next address.
- R6: While `pf_req_valid`=1 and `pf_req_ready`=0, the request and its address are held unchanged.
- R7: From the cycle a request is raised until `pf_fill` follows its acceptance, any further dead prediction is dropped. The dropped prediction changes no table or frame state, and no second request appears in the cycle after a handshake.
- R8: A `pf_fill` pulse after acceptance installs the prefetched block into frame `pf_req_addr[5:0]` with signature 0, so a later access to it hits. A `pf_fill` with no accepted prefetch is ignored.
- R9: If a fill and an access target the same frame in the same cycle, the hit decision uses the old contents and the access's update wins. An install never trains the table.
- R10: A cycle with `acc_valid`=0 produces neither `acc_hit` nor `acc_miss` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | A cache access is present this cycle |
| acc_pc | input | 16 | PC of the accessing instruction |
| acc_addr | input | 20 | Block address of the access |
| acc_hit | output | 1 | Previous cycle's access hit |
| acc_miss | output | 1 | Previous cycle's access missed and filled its frame |
| pf_req_valid | output | 1 | Prefetch request is valid |
| pf_req_ready | input | 1 | Consumer accepts the prefetch request |
| pf_req_addr | output | 20 | Block address to prefetch |
| pf_fill | input | 1 | Prefetched data has arrived; install it |

## Verification
A directed sequence repeats a fixed pattern in one frame: two touches of block A, then a miss to block B. This walks the confidence from replacement to prediction, so the cycle in which the first prefetch fires, and its address, can be checked exactly. A miss that would predict while the first prefetch is pending shows whether a busy drop is told apart from an issue. A spurious fill and a fill that returns the prefetched block show the difference between an ignored fill and an install. Random traffic is then run over three tags in four frames with four PCs, random back-pressure and random fills, and compared cycle by cycle with a bench model. This mix produces aliasing, confidence decay, same-frame fill/access collisions and held requests.

// File: rtl/dbcp_pkg.sv
package dbcp_pkg;
  typedef logic [1:0] conf_t;

  localparam conf_t CONF_TOP  = 2'd3;
  localparam conf_t CONF_FIRE = 2'd2;
  localparam conf_t CONF_SEED = 2'd1;

  function automatic conf_t conf_up(input conf_t c);
    return (c == CONF_TOP) ? c : c + 2'd1;
  endfunction

  function automatic conf_t conf_down(input conf_t c);
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/dbcp_tag_array.sv
module dbcp_tag_array #(
  parameter int FRAMES = 64,
  parameter int BLK_W  = 20,
  parameter int SIG_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [SIG_W-1:0] acc_pc,
  input  logic [BLK_W-1:0] acc_addr,
  input  logic             inst_valid,
  input  logic [BLK_W-1:0] inst_addr,
  output logic             hit,
  output logic [SIG_W-1:0] new_sig,
  output logic             victim_valid,
  output logic [BLK_W-1:0] victim_addr,
  output logic [SIG_W-1:0] victim_sig
);
  localparam int IDX_W = $clog2(FRAMES);
  localparam int TAG_W = BLK_W - IDX_W;

  logic [FRAMES-1:0] f_valid;
  logic [TAG_W-1:0]  f_tag [FRAMES];
  logic [SIG_W-1:0]  f_sig [FRAMES];

  logic [IDX_W-1:0] a_idx, i_idx;
  logic [TAG_W-1:0] a_tag;

  assign a_idx = acc_addr[IDX_W-1:0];
  assign a_tag = acc_addr[BLK_W-1:IDX_W];
  assign i_idx = inst_addr[IDX_W-1:0];

  assign hit          = f_valid[a_idx] && (f_tag[a_idx] == a_tag);
  assign new_sig      = hit ? (f_sig[a_idx] + acc_pc) : acc_pc;
  assign victim_valid = acc_valid && !hit && f_valid[a_idx];
  assign victim_addr  = {f_tag[a_idx], a_idx};
  assign victim_sig   = f_sig[a_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_valid <= '0;
    end else begin
      if (inst_valid) f_valid[i_idx] <= 1'b1;
      if (acc_valid)  f_valid[a_idx] <= 1'b1;
    end
  end

  // install first, demand access last so it wins on a shared frame
  always_ff @(posedge clk) begin
    if (inst_valid) begin
      f_tag[i_idx] <= inst_addr[BLK_W-1:IDX_W];
      f_sig[i_idx] <= '0;
    end
    if (acc_valid) begin
      f_tag[a_idx] <= a_tag;
      f_sig[a_idx] <= new_sig;
    end
  end
endmodule

// File: rtl/dbcp_corr_table.sv
module dbcp_corr_table
  import dbcp_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int BLK_W   = 20,
  parameter int SIG_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BLK_W-1:0] lk_addr,
  input  logic [SIG_W-1:0] lk_sig,
  output logic             lk_fire,
  output logic [BLK_W-1:0] lk_next,
  input  logic             tr_en,
  input  logic [BLK_W-1:0] tr_addr,
  input  logic [SIG_W-1:0] tr_sig,
  input  logic [BLK_W-1:0] tr_next
);
  localparam int CI_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] e_valid;
  logic [BLK_W-1:0]   e_tag  [ENTRIES];
  logic [BLK_W-1:0]   e_next [ENTRIES];
  conf_t              e_conf [ENTRIES];

  logic [BLK_W-1:0] lk_key, tr_key;
  logic [CI_W-1:0]  lk_idx, tr_idx;
  logic             tr_tag_eq, tr_agree;

  assign lk_key = lk_addr ^ BLK_W'(lk_sig);
  assign tr_key = tr_addr ^ BLK_W'(tr_sig);
  assign lk_idx = lk_key[CI_W-1:0];
  assign tr_idx = tr_key[CI_W-1:0];

  assign lk_fire = e_valid[lk_idx] && (e_tag[lk_idx] == lk_key) &&
                   (e_conf[lk_idx] >= CONF_FIRE);
  assign lk_next = e_next[lk_idx];

  assign tr_tag_eq = e_valid[tr_idx] && (e_tag[tr_idx] == tr_key);
  assign tr_agree  = tr_tag_eq && (e_next[tr_idx] == tr_next);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_valid <= '0;
    end else if (tr_en) begin
      e_valid[tr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (tr_en) begin
      if (tr_agree) begin
        e_conf[tr_idx] <= conf_up(e_conf[tr_idx]);
      end else if (!e_valid[tr_idx] || e_conf[tr_idx] == 2'd0) begin
        e_tag[tr_idx]  <= tr_key;
        e_next[tr_idx] <= tr_next;
        e_conf[tr_idx] <= CONF_SEED;
      end else begin
        e_conf[tr_idx] <= conf_down(e_conf[tr_idx]);
      end
    end
  end
endmodule

// File: rtl/dbcp_pf_port.sv
module dbcp_pf_port #(
  parameter int BLK_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dead_hit,
  input  logic [BLK_W-1:0] dead_next,
  input  logic             pf_ready,
  input  logic             pf_fill,
  output logic             pf_valid,
  output logic [BLK_W-1:0] pf_addr,
  output logic             inst_valid,
  output logic [BLK_W-1:0] inst_addr
);
  logic waiting;
  logic busy;

  assign busy       = pf_valid || waiting;
  assign inst_valid = pf_fill && waiting;
  assign inst_addr  = pf_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_valid <= 1'b0;
      waiting  <= 1'b0;
      pf_addr  <= '0;
    end else begin
      if (pf_valid && pf_ready) begin
        pf_valid <= 1'b0;
        waiting  <= 1'b1;
      end
      if (inst_valid) waiting <= 1'b0;
      if (dead_hit && !busy) begin
        pf_valid <= 1'b1;
        pf_addr  <= dead_next;
      end
    end
  end
endmodule

// File: rtl/dbcp_prefetcher.sv
module dbcp_prefetcher #(
  parameter int FRAMES     = 64,
  parameter int CT_ENTRIES = 64,
  parameter int BLK_W      = 20,
  parameter int SIG_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [SIG_W-1:0] acc_pc,
  input  logic [BLK_W-1:0] acc_addr,
  output logic             acc_hit,
  output logic             acc_miss,
  output logic             pf_req_valid,
  input  logic             pf_req_ready,
  output logic [BLK_W-1:0] pf_req_addr,
  input  logic             pf_fill
);
  logic             t_hit, vic_valid, inst_valid, lk_fire;
  logic [SIG_W-1:0] t_sig, vic_sig;
  logic [BLK_W-1:0] vic_addr, inst_addr, lk_next;

  dbcp_tag_array #(.FRAMES(FRAMES), .BLK_W(BLK_W), .SIG_W(SIG_W)) tags_i (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_pc(acc_pc), .acc_addr(acc_addr),
    .inst_valid(inst_valid), .inst_addr(inst_addr),
    .hit(t_hit), .new_sig(t_sig),
    .victim_valid(vic_valid), .victim_addr(vic_addr), .victim_sig(vic_sig)
  );

  dbcp_corr_table #(.ENTRIES(CT_ENTRIES), .BLK_W(BLK_W), .SIG_W(SIG_W)) corr_i (
    .clk(clk), .rst_n(rst_n),
    .lk_addr(acc_addr), .lk_sig(t_sig), .lk_fire(lk_fire), .lk_next(lk_next),
    .tr_en(vic_valid), .tr_addr(vic_addr), .tr_sig(vic_sig), .tr_next(acc_addr)
  );

  dbcp_pf_port #(.BLK_W(BLK_W)) pf_i (
    .clk(clk), .rst_n(rst_n),
    .dead_hit(acc_valid && lk_fire), .dead_next(lk_next),
    .pf_ready(pf_req_ready), .pf_fill(pf_fill),
    .pf_valid(pf_req_valid), .pf_addr(pf_req_addr),
    .inst_valid(inst_valid), .inst_addr(inst_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_hit  <= 1'b0;
      acc_miss <= 1'b0;
    end else begin
      acc_hit  <= acc_valid && t_hit;
      acc_miss <= acc_valid && !t_hit;
    end
  end
endmodule

// File: rtl/dbcp_prefetcher_chk.sv
module dbcp_prefetcher_chk #(
  parameter int BLK_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic [BLK_W-1:0] acc_addr,
  input logic             acc_hit,
  input logic             acc_miss,
  input logic             pf_req_valid,
  input logic             pf_req_ready,
  input logic [BLK_W-1:0] pf_req_addr
);
  // R2
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_hit && acc_miss));

  // R2
  access_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> (acc_hit || acc_miss));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (!acc_hit && !acc_miss));

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_req_valid && !pf_req_ready) |=> (pf_req_valid && $stable(pf_req_addr)));

  // R7
  single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_req_valid && pf_req_ready) |=> !pf_req_valid);

  // R2
  repeat_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && $past(acc_valid) && $past(rst_n) && acc_addr == $past(acc_addr))
      |=> acc_hit);
endmodule

bind dbcp_prefetcher dbcp_prefetcher_chk #(.BLK_W(BLK_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .acc_hit(acc_hit), .acc_miss(acc_miss), .pf_req_valid(pf_req_valid),
  .pf_req_ready(pf_req_ready), .pf_req_addr(pf_req_addr)
);

// File: tb/dbcp_prefetcher_tb.sv
module dbcp_prefetcher_tb_top;
  localparam int BLK_W = 20;
  localparam int SIG_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             acc_valid = 1'b0;
  logic [SIG_W-1:0] acc_pc = '0;
  logic [BLK_W-1:0] acc_addr = '0;
  logic             acc_hit, acc_miss, pf_req_valid;
  logic             pf_req_ready = 1'b0;
  logic [BLK_W-1:0] pf_req_addr;
  logic             pf_fill = 1'b0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dbcp_prefetcher dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_pc(acc_pc),
    .acc_addr(acc_addr), .acc_hit(acc_hit), .acc_miss(acc_miss),
    .pf_req_valid(pf_req_valid), .pf_req_ready(pf_req_ready),
    .pf_req_addr(pf_req_addr), .pf_fill(pf_fill)
  );

  // reference model state
  bit               mv [64];
  logic [13:0]      mt [64];
  logic [15:0]      ms [64];
  bit               cv [64];
  logic [19:0]      ctg [64];
  logic [19:0]      cn [64];
  logic [1:0]       cc [64];
  bit               m_pfv, m_wait, e_hit, e_miss;
  logic [19:0]      m_pfa;

  function automatic logic [19:0] mkey(input logic [19:0] a, input logic [15:0] s);
    return a ^ {4'b0, s};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic model(input bit av, input logic [15:0] pc, input logic [19:0] a,
                       input bit rdy, input bit fl);
    logic [5:0] idx, ci, vi, fi;
    logic [19:0] k, vk, vaddr;
    logic [15:0] ns, vsig;
    bit hit, busy, fire, vic, fgo, npv, nw;
    idx  = a[5:0];
    hit  = mv[idx] && mt[idx] == a[19:6];
    ns   = hit ? ms[idx] + pc : pc;
    busy = m_pfv || m_wait;
    k    = mkey(a, ns);
    ci   = k[5:0];
    fire = av && cv[ci] && ctg[ci] == k && cc[ci] >= 2;
    vic  = av && !hit && mv[idx];
    vaddr = {mt[idx], idx};
    vsig = ms[idx];
    fgo  = fl && m_wait;
    npv = m_pfv; nw = m_wait;
    if (m_pfv && rdy) begin npv = 0; nw = 1; end
    if (fgo) nw = 0;
    if (fgo) begin
      fi = m_pfa[5:0];
      mv[fi] = 1; mt[fi] = m_pfa[19:6]; ms[fi] = '0;
    end
    if (fire && !busy) begin npv = 1; m_pfa = cn[ci]; end
    if (av) begin mv[idx] = 1; mt[idx] = a[19:6]; ms[idx] = ns; end
    if (vic) begin
      vk = mkey(vaddr, vsig);
      vi = vk[5:0];
      if (cv[vi] && ctg[vi] == vk && cn[vi] == a)
        cc[vi] = (cc[vi] == 3) ? 2'd3 : cc[vi] + 2'd1;
      else if (!cv[vi] || cc[vi] == 0) begin
        cv[vi] = 1; ctg[vi] = vk; cn[vi] = a; cc[vi] = 1;
      end else
        cc[vi] = cc[vi] - 2'd1;
    end
    m_pfv = npv; m_wait = nw;
    e_hit = av && hit; e_miss = av && !hit;
  endtask

  // drive at negedge, model, then compare at the following negedge
  task automatic step(input bit av, input logic [15:0] pc, input logic [19:0] a,
                      input bit rdy, input bit fl, input string rq);
    acc_valid = av; acc_pc = pc; acc_addr = a; pf_req_ready = rdy; pf_fill = fl;
    model(av, pc, a, rdy, fl);
    @(posedge clk);
    @(negedge clk);
    chk(acc_hit == e_hit && acc_miss == e_miss, (av ? "R2" : "R10"),
        {acc_hit, acc_miss}, {e_hit, e_miss});
    chk(pf_req_valid == m_pfv, rq, pf_req_valid, m_pfv);
    if (m_pfv) chk(pf_req_addr == m_pfa, rq, pf_req_addr, m_pfa);
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin : main
    logic [19:0] ba, bb;
    for (int i = 0; i < 64; i++) begin mv[i] = 0; cv[i] = 0; end
    m_pfv = 0; m_wait = 0; m_pfa = '0;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!acc_hit && !acc_miss && !pf_req_valid, "R1",
        {acc_hit, acc_miss, pf_req_valid}, 3'b000);

    ba = {14'd1, 6'd5};
    bb = {14'd2, 6'd5};
    // R1: empty frames, first touch misses
    step(1, 16'h0100, ba, 1, 0, "R5");
    chk(acc_miss, "R1", acc_miss, 1);
    step(1, 16'h0204, ba, 1, 0, "R5");
    chk(acc_hit, "R3", acc_hit, 1);
    step(1, 16'h0310, bb, 1, 0, "R4");   // R4 seed A->B, conf 1
    step(1, 16'h0100, ba, 1, 0, "R4");
    step(1, 16'h0204, ba, 1, 0, "R5");
    chk(!pf_req_valid, "R5", pf_req_valid, 0); // conf 1 does not fire
    step(1, 16'h0310, bb, 1, 0, "R4");   // R4 conf 2
    step(1, 16'h0100, ba, 0, 0, "R5");
    step(1, 16'h0204, ba, 0, 0, "R5");   // R5 last touch of A
    chk(pf_req_valid && pf_req_addr == bb, "R5", pf_req_addr, bb);
    step(0, 16'h0, 20'h0, 0, 0, "R6");
    chk(pf_req_valid && pf_req_addr == bb, "R6", pf_req_addr, bb);
    step(0, 16'h0, 20'h0, 1, 0, "R7");   // handshake
    chk(!pf_req_valid, "R7", pf_req_valid, 0);
    step(1, 16'h0310, bb, 1, 0, "R7");   // would fire, but busy: dropped
    chk(!pf_req_valid, "R7", pf_req_valid, 0);
    step(1, 16'h0100, ba, 1, 1, "R8");   // install B while A misses: access wins (R9)
    step(1, 16'h0100, ba, 1, 0, "R9");
    chk(acc_hit, "R9", acc_hit, 1);
    step(0, 16'h0, 20'h0, 1, 1, "R8");   // spurious fill ignored
    step(1, 16'h0100, ba, 1, 0, "R8");
    chk(acc_hit, "R8", acc_hit, 1);

    for (int n = 0; n < 4000; n++) begin
      logic [15:0] pc;
      logic [19:0] a;
      bit av, rdy, fl;
      av  = ($urandom % 5) != 0;
      case ($urandom % 4)
        0: pc = 16'h0100;
        1: pc = 16'h0204;
        2: pc = 16'h0310;
        default: pc = 16'h0428;
      endcase
      a   = {14'(1 + $urandom % 3), 6'($urandom % 4)};
      rdy = ($urandom % 10) < 7;
      fl  = m_wait ? (($urandom % 3) == 0) : (($urandom % 16) == 0);
      step(av, pc, a, rdy, fl, "R5");
    end

    done = 1'b1;
    summary();
  end
endmodule